// File: doc/BRIEF.md
# Float32 range select unit

The unit takes two single-precision operands and a control byte and returns one of them, picked by a signed or a magnitude comparison, as either the smaller or the larger. A second stage then rewrites the sign bit of the pick. With the magnitude-minimum mode, the limit in the second operand and the sign taken from the first operand, one operation clamps a value into the symmetric band from minus limit to plus limit.

Signalling NaNs are made quiet and raise an invalid flag. Quiet NaNs lose to the other operand. Denormal inputs either raise a denormal flag or, when the flush input is high, are read as zeros of the same sign. Two cases have fixed answers: zeros of opposite sign, and equal magnitudes of opposite sign. The 32-bit result passes through a per-element write mask that can merge or zero. Lanes above the low element are copied from the first operand up to bit 127, and the rest of the output vector is cleared. The result is registered, so it appears one cycle after the input.

Top module: `range_sel_unit`

## Requirements
- R1: ctrl[1:0] picks the comparison: 00 signed minimum, 01 signed maximum, 10 smaller magnitude, 11 larger magnitude. When src1 is less than or equal to src2 under that ordering, src1 counts as the smaller. ctrl[7:4] must be zero.
- R2: ctrl[3:2] sets the sign bit of the result: 00 copies the sign of src1, 01 keeps the sign of the selected value, 10 clears it and 11 sets it. Bits [30:0] always come from the selected value.
- R3: If src1 is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is src1 with fraction bit 22 set and flag_invalid is high. Otherwise a signalling NaN in src2 gives src2 made quiet in the same way, with flag_invalid high. Sign selection is skipped whenever flag_invalid is high.
- R4: If src2 is a quiet NaN (fraction bit 22 set), src1 is selected. Otherwise, if src1 is a quiet NaN, src2 is selected. Sign selection still applies.
- R5: An operand with exponent 0 and a nonzero fraction is denormal. With flush_den high it is read as a zero of the same sign, and that zero can be selected. With flush_den low, flag_denorm is raised unless the other operand is a quiet NaN or either operand is a signalling NaN.
- R6: For a zero pair of opposite signs, the signed minimum and the smaller magnitude both give -0, and the signed maximum and the larger magnitude both give +0, whatever the operand order.
- R7: For nonzero operands of equal magnitude and opposite sign in the magnitude modes, the smaller magnitude gives the negative operand and the larger magnitude gives the positive operand.
- R8: With mask_en low or mask_bit high, dst[31:0] is the computed result. With mask_en high and mask_bit low, dst[31:0] is old_dst when mask_zero is low and 0 when mask_zero is high, and both flags read 0.
- R9: dst[127:32] equals src1[127:32], and dst bits above 127 are 0.
- R10: With ctrl = 0x02 and a positive limit in src2, a src1 whose magnitude is below the limit comes out unchanged. Any other src1 gives the limit magnitude with the sign of src1.
- R11: Outputs are registered. out_valid, dst and the flags follow an in_valid input one clock later. After reset every output is 0. Without in_valid, out_valid is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src1 | input | VLEN | First operand vector; low 32 bits are the compared value |
| src2 | input | 32 | Second operand |
| ctrl | input | 8 | Compare mode [1:0], sign mode [3:2], [7:4] must be zero |
| flush_den | input | 1 | Read denormal inputs as zeros |
| mask_en | input | 1 | Enables the per-element write mask |
| mask_bit | input | 1 | Write-mask bit of the low element |
| mask_zero | input | 1 | When masked off: 1 writes zero, 0 keeps old_dst |
| old_dst | input | 32 | Previous destination element for merging |
| out_valid | output | 1 | dst and flags are valid |
| dst | output | VLEN | Result vector |
| flag_invalid | output | 1 | A signalling NaN operand was seen |
| flag_denorm | output | 1 | A denormal operand was seen and not flushed |

## Verification
The bench aims at the points where a sloppy comparator goes wrong. Zeros of opposite sign must not fall through to operand order, which would give +0 from a minimum. Equal magnitudes of opposite sign in the magnitude modes must not return src1 by default. A signalling NaN must not pass through the sign stage, because that would flip the sign of the quiet NaN when the sign is forced. The bench also checks that a quiet NaN in src2 is beaten by src1 and not the other way round, that a flushed denormal becomes a signed zero and raises no flag, and that the clamp returns the limit with the sign of src1. Random operands drawn from zeros, denormals, infinities, both NaN kinds and normals are mixed with random masking and compared against a key-ordered reference model.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int FW    = 32;
    localparam int EXPW  = 8;
    localparam int FRACW = 23;
    localparam int MAGW  = FW - 1;
    localparam int QBIT  = FRACW - 1;

    typedef struct packed {
        logic             sgn;
        logic [EXPW-1:0]  ex;
        logic [FRACW-1:0] fr;
    } f32_t;

    typedef enum logic [1:0] {
        CMP_MIN    = 2'b00,
        CMP_MAX    = 2'b01,
        CMP_MINMAG = 2'b10,
        CMP_MAXMAG = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        SGN_SRC1 = 2'b00,
        SGN_KEEP = 2'b01,
        SGN_CLR  = 2'b10,
        SGN_SET  = 2'b11
    } sgn_mode_e;

    typedef struct packed {
        f32_t val;       // effective value (denormal flushed if requested)
        logic is_snan;
        logic is_qnan;
        logic is_zero;   // effective value is a zero
        logic den_raise; // denormal seen and not flushed
    } opnd_t;

    function automatic logic [MAGW-1:0] mag_of(f32_t x);
        return {x.ex, x.fr};
    endfunction

    function automatic f32_t quieten(f32_t x);
        f32_t q;
        q = x;
        q.fr[QBIT] = 1'b1;
        return q;
    endfunction

    function automatic logic mag_le(f32_t a, f32_t b);
        return mag_of(a) <= mag_of(b);
    endfunction

    // signed ordering for non-NaN values; zeros of opposite sign are handled elsewhere
    function automatic logic sgn_le(f32_t a, f32_t b);
        logic r;
        if (a.sgn != b.sgn)
            r = a.sgn;
        else if (!a.sgn)
            r = mag_of(a) <= mag_of(b);
        else
            r = mag_of(a) >= mag_of(b);
        return r;
    endfunction
endpackage

// File: rtl/rs_classify.sv
module rs_classify
    import rs_pkg::*;
(
    input  f32_t  raw,
    input  logic  flush_den,
    output opnd_t info
);
    logic exp_max, exp_min, frac_nz, is_nan, is_den;

    always_comb begin
        exp_max = &raw.ex;
        exp_min = ~|raw.ex;
        frac_nz = |raw.fr;
        is_nan  = exp_max && frac_nz;
        is_den  = exp_min && frac_nz;

        info.val = raw;
        if (is_den && flush_den)
            info.val.fr = '0;
        info.is_snan   = is_nan && !raw.fr[QBIT];
        info.is_qnan   = is_nan && raw.fr[QBIT];
        info.is_zero   = exp_min && (!frac_nz || flush_den);
        info.den_raise = is_den && !flush_den;
    end
endmodule

// File: rtl/rs_compare.sv
module rs_compare
    import rs_pkg::*;
(
    input  opnd_t     op_a,
    input  opnd_t     op_b,
    input  cmp_mode_e mode,
    output f32_t      pick,
    output logic      invalid,
    output logic      denorm
);
    logic opp_sign, zero_pair, tie_pair, a_first;

    always_comb begin
        opp_sign  = op_a.val.sgn != op_b.val.sgn;
        zero_pair = op_a.is_zero && op_b.is_zero && opp_sign;
        tie_pair  = opp_sign && (mag_of(op_a.val) == mag_of(op_b.val));
        invalid   = op_a.is_snan || op_b.is_snan;
        denorm    = !invalid &&
                    ((op_a.den_raise && !op_b.is_qnan) ||
                     (op_b.den_raise && !op_a.is_qnan));

        unique case (mode)
            CMP_MIN:    a_first = sgn_le(op_a.val, op_b.val);
            CMP_MAX:    a_first = !sgn_le(op_a.val, op_b.val);
            CMP_MINMAG: a_first = mag_le(op_a.val, op_b.val);
            default:    a_first = !mag_le(op_a.val, op_b.val);
        endcase

        if (op_a.is_snan)
            pick = quieten(op_a.val);
        else if (op_b.is_snan)
            pick = quieten(op_b.val);
        else if (op_b.is_qnan)
            pick = op_a.val;
        else if (op_a.is_qnan)
            pick = op_b.val;
        else if (zero_pair)
            pick = '{sgn: (mode == CMP_MIN || mode == CMP_MINMAG), ex: '0, fr: '0};
        else if (tie_pair && mode[1])
            // smaller magnitude takes the negative one, larger the positive one
            pick = ((mode == CMP_MINMAG) == op_a.val.sgn) ? op_a.val : op_b.val;
        else
            pick = a_first ? op_a.val : op_b.val;
    end
endmodule

// File: rtl/rs_finish.sv
module rs_finish
    import rs_pkg::*;
(
    input  f32_t        pick,
    input  logic        src1_sgn,
    input  logic        invalid,
    input  logic        denorm,
    input  sgn_mode_e   smode,
    input  logic        mask_en,
    input  logic        mask_bit,
    input  logic        mask_zero,
    input  logic [FW-1:0] old_dst,
    output logic [FW-1:0] lane,
    output logic        inv_out,
    output logic        den_out
);
    f32_t signed_val;
    logic write;

    always_comb begin
        signed_val = pick;
        if (!invalid) begin
            unique case (smode)
                SGN_SRC1: signed_val.sgn = src1_sgn;
                SGN_KEEP: signed_val.sgn = pick.sgn;
                SGN_CLR:  signed_val.sgn = 1'b0;
                default:  signed_val.sgn = 1'b1;
            endcase
        end

        write = !mask_en || mask_bit;
        if (write)
            lane = signed_val;
        else if (mask_zero)
            lane = '0;
        else
            lane = old_dst;
        inv_out = write && invalid;
        den_out = write && denorm;
    end
endmodule

// File: rtl/range_sel_unit.sv
module range_sel_unit
    import rs_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VLEN-1:0] src1,
    input  logic [FW-1:0]   src2,
    input  logic [7:0]      ctrl,
    input  logic            flush_den,
    input  logic            mask_en,
    input  logic            mask_bit,
    input  logic            mask_zero,
    input  logic [FW-1:0]   old_dst,
    output logic            out_valid,
    output logic [VLEN-1:0] dst,
    output logic            flag_invalid,
    output logic            flag_denorm
);
    localparam int LANE_W = 128;
    localparam int NOPS   = 2;

    f32_t      raw_ops [NOPS];
    opnd_t     info    [NOPS];
    f32_t      pick;
    logic      invalid_c, denorm_c, inv_w, den_w;
    logic [FW-1:0]   lane;
    logic [VLEN-1:0] dst_nxt;

    assign raw_ops[0] = src1[FW-1:0];
    assign raw_ops[1] = src2;

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        rs_classify u_cls (
            .raw       (raw_ops[g]),
            .flush_den (flush_den),
            .info      (info[g])
        );
    end

    rs_compare u_cmp (
        .op_a    (info[0]),
        .op_b    (info[1]),
        .mode    (cmp_mode_e'(ctrl[1:0])),
        .pick    (pick),
        .invalid (invalid_c),
        .denorm  (denorm_c)
    );

    rs_finish u_fin (
        .pick      (pick),
        .src1_sgn  (src1[FW-1]),
        .invalid   (invalid_c),
        .denorm    (denorm_c),
        .smode     (sgn_mode_e'(ctrl[3:2])),
        .mask_en   (mask_en),
        .mask_bit  (mask_bit),
        .mask_zero (mask_zero),
        .old_dst   (old_dst),
        .lane      (lane),
        .inv_out   (inv_w),
        .den_out   (den_w)
    );

    always_comb begin
        dst_nxt = '0;
        dst_nxt[LANE_W-1:FW] = src1[LANE_W-1:FW];
        dst_nxt[FW-1:0] = lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            dst          <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst          <= dst_nxt;
                flag_invalid <= inv_w;
                flag_denorm  <= den_w;
            end
        end
    end

    // R1
    ctrl_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (ctrl[7:4] == 4'b0000));

    // R3
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> (&dst[30:22]));

    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(flag_invalid && flag_denorm));

    // R2
    sign_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl[3:2] == 2'b10 && !invalid_c && (!mask_en || mask_bit))
        |=> !dst[FW-1]);

    // R8
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !mask_bit && mask_zero)
        |=> (dst[FW-1:0] == '0 && !flag_invalid && !flag_denorm));

    // R9
    upper_copy_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dst[LANE_W-1:FW] == $past(src1[LANE_W-1:FW])));

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    initial begin
        width_ok_chk: assert (VLEN >= LANE_W);
    end
endmodule

// File: tb/range_sel_unit_bench.sv
module range_sel_unit_bench;
    localparam int VLEN = 256;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [VLEN-1:0] src1;
    logic [31:0]     src2;
    logic [7:0]      ctrl;
    logic            flush_den, mask_en, mask_bit, mask_zero;
    logic [31:0]     old_dst;
    logic            out_valid;
    logic [VLEN-1:0] dst;
    logic            flag_invalid, flag_denorm;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    range_sel_unit #(.VLEN(VLEN)) u_range_sel_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src1(src1), .src2(src2),
        .ctrl(ctrl), .flush_den(flush_den), .mask_en(mask_en), .mask_bit(mask_bit),
        .mask_zero(mask_zero), .old_dst(old_dst), .out_valid(out_valid), .dst(dst),
        .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
    );

    function automatic logic signed [33:0] order_key(input logic [31:0] x);
        logic signed [33:0] m;
        m = $signed({3'b000, x[30:0]});
        return x[31] ? -m : m;
    endfunction

    // returns {invalid, denorm, value}
    function automatic logic [33:0] ref_range(input logic [31:0] a, input logic [31:0] b,
                                              input logic [7:0] c, input logic fl);
        logic a_nan, b_nan, a_sn, b_sn, a_qn, b_qn, a_dn, b_dn, a_z, b_z, inv, den;
        logic [31:0] ea, eb, t;
        logic le;
        a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_sn = a_nan && !a[22];  a_qn = a_nan && a[22];
        b_sn = b_nan && !b[22];  b_qn = b_nan && b[22];
        a_dn = (a[30:23] == 0) && (a[22:0] != 0);
        b_dn = (b[30:23] == 0) && (b[22:0] != 0);
        ea = (fl && a_dn) ? {a[31], 31'd0} : a;
        eb = (fl && b_dn) ? {b[31], 31'd0} : b;
        a_z = ea[30:0] == 0;
        b_z = eb[30:0] == 0;
        inv = a_sn || b_sn;
        den = !inv && ((a_dn && !fl && !b_qn) || (b_dn && !fl && !a_qn));
        if (a_sn) t = a | 32'h0040_0000;
        else if (b_sn) t = b | 32'h0040_0000;
        else if (b_qn) t = ea;
        else if (a_qn) t = eb;
        else if (a_z && b_z && ea[31] != eb[31]) t = c[0] ? 32'h0000_0000 : 32'h8000_0000;
        else if (c[1] && ea[31] != eb[31] && ea[30:0] == eb[30:0])
            t = (c[0] == ea[31]) ? eb : ea;
        else begin
            if (c[1]) le = ea[30:0] <= eb[30:0];
            else      le = order_key(ea) <= order_key(eb);
            t = (le != c[0]) ? ea : eb;
        end
        if (!inv) begin
            case (c[3:2])
                2'b00: t[31] = a[31];
                2'b01: t[31] = t[31];
                2'b10: t[31] = 1'b0;
                default: t[31] = 1'b1;
            endcase
        end
        return {inv, den, t};
    endfunction

    task automatic check(input string tag, input logic [VLEN+1:0] act, input logic [VLEN+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [VLEN-1:0] s1, input logic [31:0] s2,
                         input logic [7:0] c, input logic fl, input logic me, input logic mb,
                         input logic mz, input logic [31:0] od);
        logic [33:0] r;
        logic [VLEN+1:0] exp;
        @(negedge clk);
        src1 = s1; src2 = s2; ctrl = c; flush_den = fl;
        mask_en = me; mask_bit = mb; mask_zero = mz; old_dst = od;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r = ref_range(s1[31:0], s2, c, fl);
        exp = '0;
        exp[127:32] = s1[127:32];
        if (!me || mb) begin
            exp[31:0] = r[31:0];
            exp[VLEN+1] = r[33];
            exp[VLEN]   = r[32];
        end else begin
            exp[31:0] = mz ? 32'd0 : od;
        end
        check(tag, {flag_invalid, flag_denorm, dst}, exp);
        n_checks++;
        if (out_valid !== 1'b1) begin
            n_errors++;
            $display("FAIL R11 %s: out_valid actual=%b expected=1", tag, out_valid);
        end
    endtask

    function automatic logic [31:0] rnd_f32();
        logic [31:0] x;
        x = $urandom;
        case ($urandom % 8)
            0: x[30:0] = 31'd0;
            1: begin x[30:23] = 8'h00; if (x[22:0] == 0) x[0] = 1'b1; end
            2: x[30:0] = {8'hFF, 23'd0};
            3: begin x[30:23] = 8'hFF; x[22] = 1'b1; end
            4: begin x[30:23] = 8'hFF; x[22] = 1'b0; x[0] = 1'b1; end
            default: begin x[30:23] = 8'd1 + 8'($urandom % 254); end
        endcase
        return x;
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec(input logic [31:0] low);
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        v[31:0] = low;
        return v;
    endfunction

    localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
    localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] QN = 32'h7FC0_1234, SN = 32'hFF80_0055, SN2 = 32'h7F80_0077;
    localparam logic [31:0] DN = 32'h8000_0010, LIM = 32'h4316_0000;

    initial begin
        logic [31:0] a, b, seed;
        seed = $urandom(32'd20240611);
        rst = 1'b1; in_valid = 1'b0; src1 = '0; src2 = '0; ctrl = '0;
        flush_den = 0; mask_en = 0; mask_bit = 0; mask_zero = 0; old_dst = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 reset", {flag_invalid, flag_denorm, dst}, '0);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 reset out_valid actual=%b expected=0", out_valid);
        end

        // R1 compare modes
        apply("R1 min",    rnd_vec(N1), P2, 8'h04, 0, 0, 0, 0, 0);
        apply("R1 max",    rnd_vec(N1), P2, 8'h05, 0, 0, 0, 0, 0);
        apply("R1 minmag", rnd_vec(N2), P1, 8'h06, 0, 0, 0, 0, 0);
        apply("R1 maxmag", rnd_vec(N2), P1, 8'h07, 0, 0, 0, 0, 0);
        // R2 sign modes
        apply("R2 src1 sign", rnd_vec(N1), P2, 8'h01, 0, 0, 0, 0, 0);
        apply("R2 clear",     rnd_vec(N2), N1, 8'h08, 0, 0, 0, 0, 0);
        apply("R2 set",       rnd_vec(P1), P2, 8'h0C, 0, 0, 0, 0, 0);
        // R3 signalling NaN priority and bypass
        apply("R3 snan src1", rnd_vec(SN), SN2, 8'h0C, 0, 0, 0, 0, 0);
        apply("R3 snan src2", rnd_vec(QN), SN2, 8'h0C, 0, 0, 0, 0, 0);
        // R4 quiet NaN
        apply("R4 qnan src2", rnd_vec(N2), QN, 8'h04, 0, 0, 0, 0, 0);
        apply("R4 qnan src1", rnd_vec(QN), N2, 8'h0B, 0, 0, 0, 0, 0);
        // R5 denormals
        apply("R5 den flag",  rnd_vec(DN), P1, 8'h04, 0, 0, 0, 0, 0);
        apply("R5 den qnan",  rnd_vec(DN), QN, 8'h04, 0, 0, 0, 0, 0);
        apply("R5 den flush", rnd_vec(DN), P1, 8'h04, 1, 0, 0, 0, 0);
        // R6 opposite zeros
        apply("R6 min +0,-0", rnd_vec(PZ), NZ, 8'h04, 0, 0, 0, 0, 0);
        apply("R6 max -0,+0", rnd_vec(NZ), PZ, 8'h05, 0, 0, 0, 0, 0);
        apply("R6 maxmag",    rnd_vec(NZ), PZ, 8'h07, 0, 0, 0, 0, 0);
        // R7 equal magnitude ties
        apply("R7 minmag tie", rnd_vec(P2), N2, 8'h06, 0, 0, 0, 0, 0);
        apply("R7 maxmag tie", rnd_vec(N2), P2, 8'h07, 0, 0, 0, 0, 0);
        // R8 masking
        apply("R8 merge", rnd_vec(SN), P1, 8'h04, 0, 1, 0, 0, 32'hDEAD_BEEF);
        apply("R8 zero",  rnd_vec(DN), P1, 8'h04, 0, 1, 0, 1, 32'hDEAD_BEEF);
        apply("R8 write", rnd_vec(N1), P1, 8'h04, 0, 1, 1, 1, 32'hDEAD_BEEF);
        // R9 upper lanes on every apply; one explicit all-ones case
        apply("R9 upper", {VLEN{1'b1}}, P1, 8'h04, 0, 0, 0, 0, 0);
        // R10 clamp
        apply("R10 above", rnd_vec(32'h4348_0000), LIM, 8'h02, 0, 0, 0, 0, 0);
        apply("R10 below", rnd_vec(32'hC348_0000), LIM, 8'h02, 0, 0, 0, 0, 0);
        apply("R10 inside", rnd_vec(32'hC2C8_0000), LIM, 8'h02, 0, 0, 0, 0, 0);

        // R11 idle cycle drops out_valid
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 idle out_valid actual=%b expected=0", out_valid);
        end

        for (int i = 0; i < 600; i++) begin
            a = rnd_f32();
            b = (($urandom % 6) == 0) ? (a ^ 32'h8000_0000) : rnd_f32();
            apply("R1/R2/R8 random", rnd_vec(a), b, 8'($urandom % 16), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), $urandom);
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule